// File: doc/BRIEF.md
# Write-Protection Command Sequence Detector

This block sits between the strobe decoder of a parallel nonvolatile byte memory and its page buffer. It sees one event per byte load (address, data, valid strobe) and decides, per load, whether the byte goes on to the page buffer, is consumed as command data, or is refused because the array is locked. It also keeps the lock flag. The flag is held in a register whose reset value is taken from a retained input, so a reset never changes it.

Three command sequences are recognised. The unlock prefix (three loads) arms the array when it is unprotected. Once the array is locked, the same prefix lets the write that follows it through. A six-load release sequence clears the lock. A six-load wipe sequence requests a whole-array erase. While the erase runs, every load is ignored.

A partial sequence is dropped if the gap between two loads exceeds a window of `WINDOW` clock cycles. It is also dropped when a byte does not match the expected step. In that case the mismatching byte is handled as a plain write.

The state machine has these states:
- `ST_IDLE`: no sequence in progress.
- `ST_K1`: AAh@5555h seen.
- `ST_K2`: 55h@2AAAh seen.
- `ST_K3`: 80h@5555h seen.
- `ST_K4`: second AAh@5555h seen.
- `ST_K5`: second 55h@2AAAh seen.
- `ST_OPEN`: prefix complete, writes pass.
- `ST_ERASE`: erase in progress.

Its transitions are:
- `ST_IDLE`→`ST_K1` on AAh@5555h.
- `ST_K1`→`ST_K2` on 55h@2AAAh.
- `ST_K2`→`ST_OPEN` on A0h@5555h.
- `ST_K2`→`ST_K3` on 80h@5555h.
- `ST_K3`→`ST_K4` on AAh@5555h.
- `ST_K4`→`ST_K5` on 55h@2AAAh.
- `ST_K5`→`ST_IDLE` on 20h@5555h (release).
- `ST_K5`→`ST_ERASE` on 10h@5555h (wipe).
- Any of `ST_K1`..`ST_K5` or `ST_OPEN` goes to `ST_IDLE` on a mismatching byte or when the gap window expires.
- `ST_ERASE`→`ST_IDLE` on `erase_done`.

Top module: `wpd_top`

## Requirements
- R1: In every reset cycle `prot_on` is loaded from `prot_nv_in`. During and right after reset, `pass_wr`, `illegal_wr` and `erase_req` are 0.
- R2: The prefix is AAh at 5555h, then 55h at 2AAAh, then A0h at 5555h. Its three loads give neither `pass_wr` nor `illegal_wr`. When the block is unprotected, the prefix leaves `prot_on` at 0 until the next `wc_done` pulse, and `prot_on` is 1 in the cycle after that pulse.
- R3: Every load in `ST_OPEN` produces `pass_wr` = 1 in the cycle after the load, with `pass_addr`/`pass_data` equal to that load's address and data. This holds whether the block is protected or not.
- R4: While protected, a plain load that is not part of a sequence produces `illegal_wr` = 1 and `pass_wr` = 0 in the cycle after the load.
- R5: The release sequence is AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 20h@5555h. Its six loads are swallowed, and `prot_on` is 0 in the cycle after the sixth load.
- R6: The wipe sequence is the release sequence with a last byte of 10h@5555h. `erase_req` is 1 from the cycle after the sixth load until the cycle after `erase_done`. Loads made while erasing produce neither `pass_wr` nor `illegal_wr`. `prot_on` is unchanged.
- R7: A load that does not match the next expected step returns the machine to `ST_IDLE`. That load is handled as a plain write: it is stored if unprotected and refused if protected.
- R8: A sequence or an open prefix stays live while each load follows the previous one within `WINDOW` cycles. A load arriving more than `WINDOW` cycles after the previous one is treated as if the machine were in `ST_IDLE`.
- R9: While unprotected, a plain load produces `pass_wr` = 1 with its address and data in the cycle after the load.
- R10: `wr_permit` is 1 when unprotected and not erasing, or when protected and in `ST_OPEN`. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prot_nv_in | input | 1 | Retained lock value, loaded into the flag during reset |
| ld_valid | input | 1 | One-cycle byte-load event strobe |
| ld_addr | input | ADDR_W | Address of the byte load |
| ld_data | input | 8 | Data of the byte load |
| wc_done | input | 1 | Done pulse of the internal write-cycle timer |
| erase_done | input | 1 | Done pulse of the whole-array erase |
| prot_on | output | 1 | Current lock state |
| wr_permit | output | 1 | A plain write would currently be stored |
| pass_wr | output | 1 | Byte forwarded to the page buffer (pulse) |
| pass_addr | output | ADDR_W | Address of the forwarded byte |
| pass_data | output | 8 | Data of the forwarded byte |
| illegal_wr | output | 1 | Refused locked write; starts the write timers (pulse) |
| erase_req | output | 1 | Whole-array erase request, held until done |

## Verification
The bench builds the block with `WINDOW` = 8 and keeps the default key addresses 5555h and 2AAAh. With that small window, both the live case (a gap of exactly `WINDOW` cycles) and the expired case (a few cycles beyond it) can be reached with short idle waits. The locked state is entered in two ways: through the prefix followed by a `wc_done` pulse, and through a reset with `prot_nv_in` high. This lets the prefix, refusal and gap cases run under both lock states.

// File: rtl/wpd_pkg.sv
package wpd_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CODE_LEAD   = 8'hAA;
    localparam logic [BYTE_W-1:0] CODE_FOLLOW = 8'h55;
    localparam logic [BYTE_W-1:0] CODE_OPEN   = 8'hA0;
    localparam logic [BYTE_W-1:0] CODE_EXT    = 8'h80;
    localparam logic [BYTE_W-1:0] CODE_OFF    = 8'h20;
    localparam logic [BYTE_W-1:0] CODE_WIPE   = 8'h10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_K1,
        ST_K2,
        ST_K3,
        ST_K4,
        ST_K5,
        ST_OPEN,
        ST_ERASE
    } wpd_state_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_STORE,
        ACT_SWALLOW,
        ACT_REJECT
    } wpd_act_e;

    typedef struct packed {
        logic lead;
        logic follow;
        logic open;
        logic ext;
        logic off;
        logic wipe;
    } wpd_hit_t;

endpackage

// File: rtl/wpd_key_match.sv
module wpd_key_match
    import wpd_pkg::*;
#(
    parameter int                ADDR_W    = 15,
    parameter logic [ADDR_W-1:0] KEY1_ADDR = 15'h5555,
    parameter logic [ADDR_W-1:0] KEY2_ADDR = 15'h2AAA
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] data,
    output wpd_hit_t          hit
);

    // Third/sixth-step opcodes, all presented at the first key address.
    localparam int N_OPS = 4;
    localparam logic [N_OPS-1:0][BYTE_W-1:0] OPS =
        {CODE_WIPE, CODE_OFF, CODE_EXT, CODE_OPEN};

    logic             at_k1;
    logic             at_k2;
    logic [N_OPS-1:0] op_hit;

    assign at_k1 = (addr == KEY1_ADDR);
    assign at_k2 = (addr == KEY2_ADDR);

    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        assign op_hit[g] = at_k1 && (data == OPS[g]);
    end

    always_comb begin
        hit.lead   = at_k1 && (data == CODE_LEAD);
        hit.follow = at_k2 && (data == CODE_FOLLOW);
        hit.open   = op_hit[0];
        hit.ext    = op_hit[1];
        hit.off    = op_hit[2];
        hit.wipe   = op_hit[3];
    end

endmodule

// File: rtl/wpd_gap_timer.sv
module wpd_gap_timer #(
    parameter int WINDOW = 15000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ld_valid,
    output logic expired
);

    localparam int             CNT_W = $clog2(WINDOW + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(WINDOW);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld_valid) begin
            cnt_q <= '0;
        end else if (cnt_q != LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == LIM);

    // R8: a load restarts the window, so the next cycle cannot be expired
    p_gap_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> !expired);

endmodule

// File: rtl/wpd_prot_flag.sv
module wpd_prot_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic prot_nv_in,
    input  logic en_done,
    input  logic dis_done,
    input  logic wc_done,
    output logic prot_on
);

    logic prot_q;
    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q <= prot_nv_in;
            pend_q <= 1'b0;
        end else if (dis_done) begin
            prot_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (wc_done && pend_q) begin
            prot_q <= 1'b1;
            pend_q <= 1'b0;
        end else if (en_done && !prot_q) begin
            pend_q <= 1'b1;
        end
    end

    assign prot_on = prot_q;

    // R2: lock appears only on the timer done pulse
    p_lock_on_timer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_q) |-> $past(wc_done));

    // R5: lock drops only when the release sequence completes
    p_unlock_by_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_q) |-> $past(dis_done));

endmodule

// File: rtl/wpd_seq_fsm.sv
module wpd_seq_fsm
    import wpd_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [BYTE_W-1:0] ld_data,
    input  wpd_hit_t          hit,
    input  logic              prot,
    input  logic              gap_exp,
    input  logic              erase_done,
    output logic              en_done,
    output logic              dis_done,
    output logic              pass_wr,
    output logic [ADDR_W-1:0] pass_addr,
    output logic [BYTE_W-1:0] pass_data,
    output logic              illegal_wr,
    output logic              erase_req,
    output logic              wr_permit
);

    wpd_state_e st_q, st_eff, st_d;
    wpd_act_e   act;
    wpd_act_e   plain;

    logic              pass_q;
    logic              ill_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] data_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // A partial sequence or open prefix dies once the load gap runs out
    always_comb begin
        st_eff = st_q;
        if (gap_exp && (st_q != ST_IDLE) && (st_q != ST_ERASE))
            st_eff = ST_IDLE;
    end

    assign plain = prot ? ACT_REJECT : ACT_STORE;

    // Next state and per-load decision
    always_comb begin
        st_d     = st_eff;
        act      = ACT_NONE;
        en_done  = 1'b0;
        dis_done = 1'b0;
        unique case (st_eff)
            ST_IDLE: begin
                if (ld_valid) begin
                    if (hit.lead) begin
                        st_d = ST_K1;
                        act  = ACT_SWALLOW;
                    end else begin
                        act  = plain;
                    end
                end
            end
            ST_K1: begin
                if (ld_valid) begin
                    if (hit.follow) begin
                        st_d = ST_K2;
                        act  = ACT_SWALLOW;
                    end else begin
                        st_d = ST_IDLE;
                        act  = plain;
                    end
                end
            end
            ST_K2: begin
                if (ld_valid) begin
                    if (hit.open) begin
                        st_d    = ST_OPEN;
                        act     = ACT_SWALLOW;
                        en_done = 1'b1;
                    end else if (hit.ext) begin
                        st_d = ST_K3;
                        act  = ACT_SWALLOW;
                    end else begin
                        st_d = ST_IDLE;
                        act  = plain;
                    end
                end
            end
            ST_K3: begin
                if (ld_valid) begin
                    if (hit.lead) begin
                        st_d = ST_K4;
                        act  = ACT_SWALLOW;
                    end else begin
                        st_d = ST_IDLE;
                        act  = plain;
                    end
                end
            end
            ST_K4: begin
                if (ld_valid) begin
                    if (hit.follow) begin
                        st_d = ST_K5;
                        act  = ACT_SWALLOW;
                    end else begin
                        st_d = ST_IDLE;
                        act  = plain;
                    end
                end
            end
            ST_K5: begin
                if (ld_valid) begin
                    if (hit.off) begin
                        st_d     = ST_IDLE;
                        act      = ACT_SWALLOW;
                        dis_done = 1'b1;
                    end else if (hit.wipe) begin
                        st_d = ST_ERASE;
                        act  = ACT_SWALLOW;
                    end else begin
                        st_d = ST_IDLE;
                        act  = plain;
                    end
                end
            end
            ST_OPEN: begin
                if (ld_valid) act = ACT_STORE;
            end
            ST_ERASE: begin
                if (erase_done) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Registered load outcome
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_q <= 1'b0;
            ill_q  <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            pass_q <= (act == ACT_STORE);
            ill_q  <= (act == ACT_REJECT);
            if (act == ACT_STORE) begin
                addr_q <= ld_addr;
                data_q <= ld_data;
            end
        end
    end

    assign pass_wr    = pass_q;
    assign pass_addr  = addr_q;
    assign pass_data  = data_q;
    assign illegal_wr = ill_q;
    assign erase_req  = (st_q == ST_ERASE);
    assign wr_permit  = prot ? (st_q == ST_OPEN) : (st_q != ST_ERASE);

    // R4: a refusal is only ever issued while the flag was set
    p_reject_needs_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ill_q |-> $past(prot));

    // R3: a forwarded byte always traces back to a load strobe
    p_pass_from_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pass_q |-> $past(ld_valid));

    // R6: nothing is stored or refused while erasing
    p_erase_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ERASE) |=> (!pass_q && !ill_q));

    // R6: erase request holds until the done pulse
    p_erase_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && !erase_done) |=> erase_req);

endmodule

// File: rtl/wpd_top.sv
module wpd_top
    import wpd_pkg::*;
#(
    parameter int                ADDR_W    = 15,
    parameter int                WINDOW    = 15000,
    parameter logic [ADDR_W-1:0] KEY1_ADDR = 15'h5555,
    parameter logic [ADDR_W-1:0] KEY2_ADDR = 15'h2AAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_nv_in,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [7:0]        ld_data,
    input  logic              wc_done,
    input  logic              erase_done,
    output logic              prot_on,
    output logic              wr_permit,
    output logic              pass_wr,
    output logic [ADDR_W-1:0] pass_addr,
    output logic [7:0]        pass_data,
    output logic              illegal_wr,
    output logic              erase_req
);

    wpd_hit_t hit;
    logic     gap_exp;
    logic     en_done;
    logic     dis_done;

    wpd_key_match #(
        .ADDR_W   (ADDR_W),
        .KEY1_ADDR(KEY1_ADDR),
        .KEY2_ADDR(KEY2_ADDR)
    ) u_match (
        .addr(ld_addr),
        .data(ld_data),
        .hit (hit)
    );

    wpd_gap_timer #(
        .WINDOW(WINDOW)
    ) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_valid(ld_valid),
        .expired (gap_exp)
    );

    wpd_prot_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .prot_nv_in(prot_nv_in),
        .en_done   (en_done),
        .dis_done  (dis_done),
        .wc_done   (wc_done),
        .prot_on   (prot_on)
    );

    wpd_seq_fsm #(
        .ADDR_W(ADDR_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_valid  (ld_valid),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .hit       (hit),
        .prot      (prot_on),
        .gap_exp   (gap_exp),
        .erase_done(erase_done),
        .en_done   (en_done),
        .dis_done  (dis_done),
        .pass_wr   (pass_wr),
        .pass_addr (pass_addr),
        .pass_data (pass_data),
        .illegal_wr(illegal_wr),
        .erase_req (erase_req),
        .wr_permit (wr_permit)
    );

endmodule

// File: tb/wpd_top_bench.sv
module wpd_top_bench;

    localparam int ADDR_W = 15;
    localparam int WIN    = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              prot_nv_in = 1'b0;
    logic              ld_valid = 1'b0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic [7:0]        ld_data = '0;
    logic              wc_done = 1'b0;
    logic              erase_done = 1'b0;
    logic              prot_on, wr_permit, pass_wr, illegal_wr, erase_req;
    logic [ADDR_W-1:0] pass_addr;
    logic [7:0]        pass_data;

    int nchk = 0;
    int nerr = 0;

    always #5 clk = ~clk;

    wpd_top #(.ADDR_W(ADDR_W), .WINDOW(WIN)) u_wpd_top (
        .clk(clk), .rst_n(rst_n), .prot_nv_in(prot_nv_in),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data),
        .wc_done(wc_done), .erase_done(erase_done),
        .prot_on(prot_on), .wr_permit(wr_permit), .pass_wr(pass_wr),
        .pass_addr(pass_addr), .pass_data(pass_data),
        .illegal_wr(illegal_wr), .erase_req(erase_req)
    );

    // op: 0 load, 1 write-timer done pulse, 2 idle gap past the window
    // fields: {op[1:0], addr[14:0], data[7:0], exp_pass, exp_ill, exp_prot}
    localparam int NV = 27;
    localparam logic [27:0] VEC [NV] = '{
        {2'd0, 15'h0123, 8'h11, 3'b100},  // R9 plain store
        {2'd0, 15'h5555, 8'hAA, 3'b000},  // R2 prefix
        {2'd0, 15'h2AAA, 8'h55, 3'b000},
        {2'd0, 15'h5555, 8'hA0, 3'b000},  // R2 still unlocked
        {2'd0, 15'h0040, 8'h33, 3'b100},  // R3 open
        {2'd1, 15'h0000, 8'h00, 3'b001},  // R2 timer done -> locked
        {2'd2, 15'h0000, 8'h00, 3'b001},
        {2'd0, 15'h0100, 8'h44, 3'b011},  // R4 refused
        {2'd0, 15'h5555, 8'hAA, 3'b001},
        {2'd0, 15'h2AAA, 8'h55, 3'b001},
        {2'd0, 15'h5555, 8'hA0, 3'b001},
        {2'd0, 15'h0200, 8'h55, 3'b101},  // R3 locked but prefixed
        {2'd0, 15'h0201, 8'h66, 3'b101},
        {2'd2, 15'h0000, 8'h00, 3'b001},
        {2'd0, 15'h0300, 8'h77, 3'b011},  // R4
        {2'd0, 15'h5555, 8'hAA, 3'b001},
        {2'd0, 15'h2AAA, 8'h55, 3'b001},
        {2'd0, 15'h1234, 8'h99, 3'b011},  // R7 mismatch while locked
        {2'd0, 15'h5555, 8'hAA, 3'b001},  // R5 release
        {2'd0, 15'h2AAA, 8'h55, 3'b001},
        {2'd0, 15'h5555, 8'h80, 3'b001},
        {2'd0, 15'h5555, 8'hAA, 3'b001},
        {2'd0, 15'h2AAA, 8'h55, 3'b001},
        {2'd0, 15'h5555, 8'h20, 3'b000},  // R5 unlocked
        {2'd0, 15'h0400, 8'h12, 3'b100},
        {2'd0, 15'h5555, 8'hAA, 3'b000},
        {2'd0, 15'h0500, 8'h77, 3'b100}   // R7 mismatch while unlocked
    };

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string what);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", what, got, exp);
        end
    endtask

    task automatic do_load(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        ld_valid = 1'b1;
        ld_addr  = a;
        ld_data  = d;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic pulse_wc();
        @(negedge clk);
        wc_done = 1'b1;
        @(negedge clk);
        wc_done = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic do_reset(input logic nv);
        @(negedge clk);
        prot_nv_in = nv;
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        // R1/R10: reset with an unlocked retained value
        do_reset(1'b0);
        check(prot_on, 0, "R1 prot after reset");
        check(pass_wr, 0, "R1 pass after reset");
        check(illegal_wr, 0, "R1 illegal after reset");
        check(erase_req, 0, "R1 erase after reset");
        check(wr_permit, 1, "R10 permit when unlocked");

        // Table walk: R2 R3 R4 R5 R7 R9
        for (int i = 0; i < NV; i++) begin
            logic [27:0] v;
            v = VEC[i];
            case (v[27:26])
                2'd0:    do_load(v[25:11], v[10:3]);
                2'd1:    pulse_wc();
                default: idle(WIN + 3);
            endcase
            if (v[27:26] != 2'd2) begin
                check(pass_wr, v[2], $sformatf("row %0d R3/R9 pass", i));
                check(illegal_wr, v[1], $sformatf("row %0d R4/R7 illegal", i));
                if (v[2]) begin
                    check(pass_addr, v[25:11], $sformatf("row %0d R3/R9 addr", i));
                    check(pass_data, v[10:3], $sformatf("row %0d R3/R9 data", i));
                end
            end
            check(prot_on, v[0], $sformatf("row %0d R2/R5 prot", i));
        end

        // R6: wipe sequence while unlocked
        do_load(15'h5555, 8'hAA);
        do_load(15'h2AAA, 8'h55);
        do_load(15'h5555, 8'h80);
        do_load(15'h5555, 8'hAA);
        do_load(15'h2AAA, 8'h55);
        do_load(15'h5555, 8'h10);
        check(erase_req, 1, "R6 erase requested");
        check(pass_wr, 0, "R6 wipe byte swallowed");
        check(wr_permit, 0, "R10 permit low while erasing");
        do_load(15'h0600, 8'hAB);
        check(pass_wr, 0, "R6 load ignored during erase");
        check(illegal_wr, 0, "R6 no refusal during erase");
        check(erase_req, 1, "R6 erase still held");
        check(prot_on, 0, "R6 lock unchanged");
        @(negedge clk);
        erase_done = 1'b1;
        @(negedge clk);
        erase_done = 1'b0;
        check(erase_req, 0, "R6 erase released");
        do_load(15'h0601, 8'hCD);
        check(pass_wr, 1, "R6 store after erase");
        check(pass_data, 8'hCD, "R6 data after erase");

        // R1: retained lock survives reset
        do_reset(1'b1);
        check(prot_on, 1, "R1 retained lock");
        check(wr_permit, 0, "R10 permit low when locked");

        // R8: gaps of exactly WINDOW keep the prefix alive
        do_load(15'h5555, 8'hAA);
        idle(WIN - 2);
        do_load(15'h2AAA, 8'h55);
        idle(WIN - 2);
        do_load(15'h5555, 8'hA0);
        check(wr_permit, 1, "R10 permit when prefixed");
        idle(WIN - 2);
        do_load(15'h0700, 8'hEE);
        check(pass_wr, 1, "R8 within window store");
        check(pass_addr, 15'h0700, "R8 within window addr");

        // R8: a longer gap abandons the partial sequence
        idle(WIN + 3);
        do_load(15'h5555, 8'hAA);
        idle(WIN + 3);
        do_load(15'h2AAA, 8'h55);
        check(illegal_wr, 1, "R8 abandoned sequence refused");
        check(pass_wr, 0, "R8 abandoned sequence not stored");

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule